// File: doc/BRIEF.md
# Serialized Kernel Launch Controller

This block places a small control word behind an AXI4-Lite slave port and uses it to run an attached compute core one job at a time. Software writes a 1 to the launch bit of the control word at byte offset 0x0. The controller then sends a one-cycle start pulse to the core and waits for the core's one-cycle completion pulse. That completion is latched into a sticky flag, which software polls. Reading the control word returns the flag and clears it. While a job is running, further launch requests are dropped, so jobs can never overlap.

The controller is built around a three-state run machine. `K_IDLE` waits for a launch. A launch write moves it to `K_LAUNCH` (transition *accept*). `K_LAUNCH` drives the start pulse for exactly one cycle and always moves to `K_BUSY` (transition *issue*). `K_BUSY` waits for the completion pulse and then returns to `K_IDLE` (transition *finish*). The block also has a 32-bit scratch word at offset 0x4 for passing an argument. A stand-in core with a programmable latency, `kctl_stub_core`, is included for testing.

Top module: `seq_kernel_ctrl`

## Requirements
- R1: The control word at offset 0x0 reads as follows: bit 0 is launch-pending, bit 1 is the sticky completion flag, bit 2 is idle, and bits 31..3 read 0. After reset it reads 0x0000_0004.
- R2: A write to 0x0 with wstrb[0]=1 and wdata[0]=1, made while idle, produces exactly one `core_start` pulse lasting one cycle. The launch-pending bit then clears by itself, so a read taken after the write response returns 0x0 while the job runs.
- R3: A launch write made while a job is in progress is ignored. No extra `core_start` pulse occurs, and the running job completes normally.
- R4: A `core_done` pulse during a job sets the completion flag. The flag stays set until software reads the control word; that read returns bit 1 = 1 and clears the flag, so the next read returns 0x0000_0004.
- R5: A `core_done` pulse that arrives while no job is running is ignored, and the completion flag stays 0.
- R6: The idle bit is 1 exactly when no job has been launched and left uncompleted.
- R7: Three jobs requested in turn by the host flow (launch, poll until done, repeat) produce start and completion events that strictly alternate: start, done, start, done, start, done.
- R8: The write-address and write-data channels are accepted independently and in either order. `s_bvalid` rises only after both have been accepted, and it is held until `s_bready`.
- R9: Every write and read response is OKAY (2'b00). `s_rvalid` and `s_rdata` are held steady until `s_rready`.
- R10: The scratch word at 0x4 is read/write with per-byte strobes. Any other offset reads 0, and writes to it are ignored.
- R11: A write to 0x0 with wdata[0]=0, or with wstrb[0]=0, launches nothing. Bits 31..1 of a write to 0x0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_done | input | 1 | One-cycle completion pulse from the core |

## Verification
The bound checker checks several properties on every cycle:
- each start pulse is one cycle wide;
- no start pulse occurs while a job is still open;
- the idle bit is low throughout an open job;
- the completion flag rises only after a completion pulse;
- the response channels hold and stay OKAY.

Other behaviour depends on what software sees and can only be shown by the bench's scenarios:
- clear-on-read of the completion flag;
- dropping of launches while busy and of stray completions;
- byte-strobe merging in the scratch word;
- either-order acceptance of the write channels;
- strict start/done alternation across three host-driven jobs.

// File: rtl/kctl_pkg.sv
package kctl_pkg;
    typedef enum logic [1:0] {
        K_IDLE   = 2'd0,
        K_LAUNCH = 2'd1,
        K_BUSY   = 2'd2
    } run_state_e;

    localparam int unsigned CTRL_OFF    = 0;
    localparam int unsigned SCRATCH_OFF = 4;
    localparam logic [1:0]  RESP_OKAY   = 2'b00;
endpackage

// File: rtl/kctl_axil_wr.sv
module kctl_axil_wr #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);
    logic aw_held, w_held;

    assign awready = !aw_held && !bvalid;
    assign wready  = !w_held && !bvalid;
    assign wr_fire = aw_held && w_held && !bvalid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                wr_addr <= awaddr;
            end
            if (wvalid && wready) begin
                w_held  <= 1'b1;
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
            if (wr_fire) begin
                aw_held <= 1'b0;
                w_held  <= 1'b0;
                bvalid  <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/kctl_axil_rd.sv
module kctl_axil_rd #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_value
);
    assign arready = !rvalid;
    assign rd_fire = arvalid && arready;
    assign rd_addr = araddr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            rdata  <= rd_value;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/kctl_run_fsm.sv
module kctl_run_fsm
    import kctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic core_done,
    output logic core_start,
    output logic launch_bit,
    output logic idle,
    output logic done_set
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= K_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            K_IDLE:   if (launch_req) state_d = K_LAUNCH;
            K_LAUNCH: state_d = K_BUSY;
            K_BUSY:   if (core_done) state_d = K_IDLE;
            default:  state_d = K_IDLE;
        endcase
    end

    always_comb begin
        core_start = 1'b0;
        launch_bit = 1'b0;
        idle       = 1'b0;
        done_set   = 1'b0;
        unique case (state_q)
            K_IDLE:   idle = 1'b1;
            K_LAUNCH: begin
                core_start = 1'b1;
                launch_bit = 1'b1;
            end
            K_BUSY:   done_set = core_done;
            default:  idle = 1'b1;
        endcase
    end
endmodule

// File: rtl/kctl_stub_core.sv
module kctl_stub_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] lat_i,
    output logic             done_o
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= (lat_i == '0) ? CNT_W'(1) : lat_i;
            end else if (busy_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/seq_kernel_ctrl.sv
module seq_kernel_ctrl
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic                core_start,
    input  logic                core_done
);
    localparam int STRB_W = DATA_W / 8;

    logic              wr_fire, rd_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_value, scratch_q, ctrl_word;
    logic [STRB_W-1:0] wr_strb;
    logic              launch_req, launch_bit, fsm_idle, done_set, done_q;
    logic              wr_is_ctrl, wr_is_scr;

    kctl_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
    );

    kctl_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
        .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_value(rd_value)
    );

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

    assign wr_is_ctrl = (wr_addr == ADDR_W'(CTRL_OFF));
    assign wr_is_scr  = (wr_addr == ADDR_W'(SCRATCH_OFF));
    assign launch_req = wr_fire && wr_is_ctrl && wr_strb[0] && wr_data[0];

    kctl_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .launch_req(launch_req), .core_done(core_done),
        .core_start(core_start), .launch_bit(launch_bit),
        .idle(fsm_idle), .done_set(done_set)
    );

    // Sticky completion flag: a new completion wins over clear-on-read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (done_set)
            done_q <= 1'b1;
        else if (rd_fire && rd_addr == ADDR_W'(CTRL_OFF))
            done_q <= 1'b0;
    end

    for (genvar b = 0; b < STRB_W; b++) begin : g_scr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                scratch_q[8*b +: 8] <= 8'h00;
            else if (wr_fire && wr_is_scr && wr_strb[b])
                scratch_q[8*b +: 8] <= wr_data[8*b +: 8];
        end
    end

    always_comb begin
        ctrl_word    = '0;
        ctrl_word[0] = launch_bit;
        ctrl_word[1] = done_q;
        ctrl_word[2] = fsm_idle;
    end

    always_comb begin
        if (rd_addr == ADDR_W'(CTRL_OFF))         rd_value = ctrl_word;
        else if (rd_addr == ADDR_W'(SCRATCH_OFF)) rd_value = scratch_q;
        else                                      rd_value = '0;
    end
endmodule

// File: rtl/kctl_chk.sv
module kctl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_start,
    input logic              core_done,
    input logic              idle,
    input logic              done_q,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp
);
    logic run_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_open <= 1'b0;
        else if (core_start) run_open <= 1'b1;
        else if (core_done)  run_open <= 1'b0;
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !run_open);

    // R6
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_open |-> !idle);

    // R4
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(core_done));

    // R8
    bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    // R9
    resp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid |-> bresp == 2'b00) and (rvalid |-> rresp == 2'b00));
endmodule

bind seq_kernel_ctrl kctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .core_start(core_start), .core_done(core_done),
    .idle(fsm_idle), .done_q(done_q),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp)
);

// File: tb/seq_kernel_ctrl_tb.sv
module seq_kernel_ctrl_tb;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic          awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
    logic          arvalid = 1'b0, rready = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    wstrb = '0;
    logic          awready, wready, bvalid, arready, rvalid;
    logic [1:0]    bresp, rresp;
    logic [DW-1:0] rdata;
    logic          core_start, stub_done, core_done;
    logic          inj_done = 1'b0;
    logic [7:0]    lat = 8'd10;

    int checks = 0;
    int failures = 0;
    int n_start = 0;
    int n_done = 0;
    int ev_n = 0;
    byte ev_log [0:31];

    always #5 clk = ~clk;

    assign core_done = stub_done | inj_done;

    seq_kernel_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .core_start(core_start), .core_done(core_done)
    );

    kctl_stub_core #(.CNT_W(8)) u_core (
        .clk(clk), .rst_n(rst_n), .start_i(core_start), .lat_i(lat), .done_o(stub_done)
    );

    always @(posedge clk) begin
        if (rst_n && core_start) begin
            n_start <= n_start + 1;
            if (ev_n < 32) ev_log[ev_n] <= "S";
            ev_n <= ev_n + 1;
        end else if (rst_n && stub_done) begin
            n_done <= n_done + 1;
            if (ev_n < 32) ev_log[ev_n] <= "D";
            ev_n <= ev_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic chan_loop();
        while (awvalid || wvalid) begin
            automatic logic a_acc = awvalid && awready;
            automatic logic w_acc = wvalid && wready;
            @(negedge clk);
            if (a_acc) awvalid = 1'b0;
            if (w_acc) wvalid = 1'b0;
        end
    endtask

    // order: 0 both together, 1 address first, 2 data first
    task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int order);
        awaddr = a; wdata = d; wstrb = s;
        if (order == 0) begin
            awvalid = 1'b1; wvalid = 1'b1; chan_loop();
        end else begin
            if (order == 1) awvalid = 1'b1; else wvalid = 1'b1;
            chan_loop();
            repeat (2) @(negedge clk);
            check("R8 no response before both channels", {31'b0, bvalid}, 32'd0);
            if (order == 1) wvalid = 1'b1; else awvalid = 1'b1;
            chan_loop();
        end
        while (!bvalid) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R8 response held until bready", {31'b0, bvalid}, 32'd1);
        check("R9 bresp OKAY", {30'b0, bresp}, 32'd0);
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] d);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        d = rdata;
        checks++;
        if (rresp !== 2'b00) begin
            failures++;
            $display("FAIL R9 rresp actual=%0d expected=0", rresp);
        end
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        axi_read(12'h000, v);
        check("R1 reset control word", v, 32'h4);
        axi_read(12'h004, v);
        check("R10 reset scratch", v, 32'h0);
    endtask

    task automatic t_single_run();
        logic [31:0] v;
        int s0 = n_start;
        lat = 8'd30;
        axi_write(12'h000, 32'h1, 4'hF, 0);
        axi_read(12'h000, v);
        check("R2 launch bit self-clears, R6 not idle", v, 32'h0);
        check("R2 one start pulse", n_start - s0, 1);
        repeat (40) @(negedge clk);
        axi_read(12'h000, v);
        check("R4 done flag reads 1 with idle", v, 32'h6);
        axi_read(12'h000, v);
        check("R4 done flag cleared by read", v, 32'h4);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int s0 = n_start;
        int d0 = n_done;
        lat = 8'd60;
        axi_write(12'h000, 32'h1, 4'hF, 1);
        axi_write(12'h000, 32'h1, 4'hF, 2);
        axi_read(12'h000, v);
        check("R3 still busy after ignored launch", v, 32'h0);
        repeat (70) @(negedge clk);
        check("R3 only one start pulse", n_start - s0, 1);
        check("R3 run completed once", n_done - d0, 1);
        axi_read(12'h000, v);
        check("R3 done after ignored launch", v, 32'h6);
    endtask

    task automatic t_stray_done();
        logic [31:0] v;
        @(negedge clk); inj_done = 1'b1;
        @(negedge clk); inj_done = 1'b0;
        axi_read(12'h000, v);
        check("R5 stray done ignored", v, 32'h4);
    endtask

    task automatic t_no_launch();
        logic [31:0] v;
        int s0 = n_start;
        axi_write(12'h000, 32'hFFFF_FFFE, 4'hF, 0);
        axi_write(12'h000, 32'h0000_0001, 4'hE, 0);
        repeat (5) @(negedge clk);
        check("R11 no start pulse", n_start - s0, 0);
        axi_read(12'h000, v);
        check("R11 control word unchanged", v, 32'h4);
    endtask

    task automatic t_scratch();
        logic [31:0] v;
        axi_write(12'h004, 32'hA5A5_1234, 4'hF, 2);
        axi_read(12'h004, v);
        check("R10 scratch full write", v, 32'hA5A5_1234);
        axi_write(12'h004, 32'hFFFF_FFFF, 4'b0010, 0);
        axi_read(12'h004, v);
        check("R10 scratch byte strobe", v, 32'hA5A5_FF34);
        axi_write(12'h008, 32'h1, 4'hF, 0);
        axi_read(12'h008, v);
        check("R10 unmapped reads zero", v, 32'h0);
        axi_read(12'h000, v);
        check("R10 unmapped write launches nothing", v, 32'h4);
    endtask

    task automatic t_three_runs();
        logic [31:0] v;
        int base = ev_n;
        int tries;
        for (int j = 0; j < 3; j++) begin
            lat = 8'(5 + 7 * j);
            axi_write(12'h000, 32'h1, 4'h1, j % 3);
            tries = 0;
            v = 0;
            while (!v[1] && tries < 100) begin
                axi_read(12'h000, v);
                tries++;
            end
            check("R7 host poll sees done", {31'b0, v[1]}, 32'd1);
        end
        @(negedge clk);
        check("R7 event count", ev_n - base, 6);
        for (int k = 0; k < 6; k++)
            check("R7 start/done alternate", {24'b0, ev_log[base + k]},
                  (k % 2 == 0) ? 32'h53 : 32'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_run();
        t_busy_ignore();
        t_stray_done();
        t_no_launch();
        t_scratch();
        t_three_runs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule